// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible face of a serial port controller. It decodes a 6-bit byte offset on a simple single-cycle read/write bus. It holds a pair of mode registers that share one offset and are selected by a pointer that moves forward after a write. It also keeps the transmitter and receiver enables, an interrupt mask and a delta-break latch. The interrupt status byte and the interrupt request are formed from these registers.

Bytes written to the transmit buffer leave the block on a valid/ready byte stream. A separate receive queue block reports its state through two level inputs (has data, is full) and a head-of-queue data bus. The front end returns the head byte on a data read and tells the queue to advance with a pop strobe. A command byte carries three fields that act in a fixed order in one write:
- a miscellaneous action,
- a transmitter enable/disable,
- a receiver enable/disable.

The serial shifter, the baud generator and any input-port change logic lie outside the block. The two divider bytes are read-only constants set by parameters.

Top module: `uart_regbank`

## Requirements
- R1: After reset the status byte (offset 0x04) reads 0x08 with an empty receive queue, both mode registers read 0, the mask is 0, `irq` is low, `txs_valid` and `rx_enable` are low.
- R2: Offset 0x00 reads and writes mode register `ptr`. The pointer starts at 0 and becomes 1 after any write there. Command field bits[6:4] = 1 returns it to 0.
- R3: A read returns its data on `bus_rdata` in the cycle after `bus_rd`, and `bus_rdata` holds until the next read. The status byte is {4'b0, tx empty (bit3), tx enabled (bit2), `rxq_full` (bit1), `rxq_avail` (bit0)}.
- R4: Command bits[3:2] control the transmitter and bits[1:0] the receiver, with the same code for both: 1 enables, 2 disables, 0 and 3 leave the enable unchanged. `rx_enable` shows the receiver enable.
- R5: In one command byte the miscellaneous field acts first, then the transmitter field, then the receiver field. Misc code 2 clears the receiver enable and raises `rxq_flush` in the cycle of the write. Misc code 3 clears the transmitter enable and marks the buffer empty. A same-byte enable code wins over either reset.
- R6: A write to offset 0x0C latches the byte and clears the empty flag. `txs_valid` is high while a byte is held and the transmitter is enabled, with the byte on `txs_data`. A handshake (`txs_valid` and `txs_ready`) sets the empty flag.
- R7: A write to 0x0C while a byte is held replaces it. A write that falls in the handshake cycle keeps the new byte pending, so both bytes are sent in order.
- R8: A read at 0x0C with `rxq_avail` high returns `rxq_data` and raises `rxq_pop` in the read cycle. With the queue empty the read returns 0 and no pop is raised.
- R9: The interrupt status (read at 0x14) has bit0 = tx enabled, bit1 = `rxq_full` if mode register 0 bit6 is 1 and `rxq_avail` otherwise, bit2 = delta-break latch, and all other bits 0.
- R10: A write at 0x14 sets the mask. `irq` is high exactly when (interrupt status AND mask) is nonzero, one cycle after the register change.
- R11: A `rx_break` pulse sets the delta-break latch and misc code 5 clears it. If both happen in the same cycle the latch stays set.
- R12: Writes at 0x04, 0x10, 0x18 and 0x1C change nothing. Reads at 0x10 and unmapped offsets return 0, and 0x18/0x1C return parameters `DIV_A_VAL`/`DIV_B_VAL`.
- R13: A transmitter reset (misc code 3) discards a held byte: `txs_valid` drops and the byte is never sent, even when the transmitter is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |
| txs_valid | output | 1 | Transmit byte valid |
| txs_ready | input | 1 | Transmit sink ready |
| txs_data | output | DATA_W | Transmit byte |
| rxq_avail | input | 1 | Receive queue holds data |
| rxq_full | input | 1 | Receive queue full |
| rxq_data | input | DATA_W | Receive queue head byte |
| rxq_pop | output | 1 | Advance receive queue |
| rxq_flush | output | 1 | Empty receive queue |
| rx_break | input | 1 | Break event pulse |
| rx_enable | output | 1 | Receiver enable |

## Verification
Two pairs of actions can land on one clock edge. The first pair is a transmit-buffer write and a stream handshake. The bench keeps `txs_ready` high and issues two buffer writes back to back, so the second write meets the handshake of the first byte. It then compares the log of sent bytes with the expected order. The second pair is a break event and the break-clear command: the bench raises `rx_break` in the same cycle as the clear write and expects the latch, seen through the interrupt status read and `irq`, to stay set. A behavioural model with a byte queue standing in for the receive queue is compared with every output on each clock.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

  localparam logic [5:0] OFS_MODE = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_DATA = 6'h0C;
  localparam logic [5:0] OFS_AUX  = 6'h10;
  localparam logic [5:0] OFS_INT  = 6'h14;
  localparam logic [5:0] OFS_DIVA = 6'h18;
  localparam logic [5:0] OFS_DIVB = 6'h1C;

  // status bit positions
  localparam int ST_RXAV  = 0;
  localparam int ST_RXFL  = 1;
  localparam int ST_TXEN  = 2;
  localparam int ST_TXEMP = 3;

  // interrupt status bit positions
  localparam int IS_TX  = 0;
  localparam int IS_RX  = 1;
  localparam int IS_BRK = 2;

  // mode register 0 bit choosing the receive interrupt source
  localparam int MODE_RXSEL = 6;

  typedef enum logic [2:0] {
    MISC_NOP_A  = 3'd0,
    MISC_PTR0   = 3'd1,
    MISC_RXRST  = 3'd2,
    MISC_TXRST  = 3'd3,
    MISC_NOP_B  = 3'd4,
    MISC_BRKCLR = 3'd5,
    MISC_NOP_C  = 3'd6,
    MISC_NOP_D  = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_ON   = 2'd1,
    EN_OFF  = 2'd2,
    EN_RSVD = 2'd3
  } en_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;

endpackage

// File: rtl/uart_rb_cmd_dec.sv
module uart_rb_cmd_dec
  import uart_rb_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [6:0] cmd,
  output cmd_act_t   act
);

  misc_e misc;
  en_e   txf;
  en_e   rxf;

  assign misc = misc_e'(cmd[6:4]);
  assign txf  = en_e'(cmd[3:2]);
  assign rxf  = en_e'(cmd[1:0]);

  always_comb begin
    act = '0;
    if (cmd_wr) begin
      unique case (misc)
        MISC_PTR0:   act.ptr_rst = 1'b1;
        MISC_RXRST:  act.rx_rst  = 1'b1;
        MISC_TXRST:  act.tx_rst  = 1'b1;
        MISC_BRKCLR: act.brk_clr = 1'b1;
        default:     ;
      endcase
      act.tx_on  = (txf == EN_ON);
      act.tx_off = (txf == EN_OFF);
      act.rx_on  = (rxf == EN_ON);
      act.rx_off = (rxf == EN_OFF);
    end
  end

endmodule

// File: rtl/uart_rb_tx_hold.sv
module uart_rb_tx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              tx_rst,
  input  logic              tx_on,
  input  logic              tx_off,
  input  logic              txs_ready,
  output logic              txs_valid,
  output logic [DATA_W-1:0] txs_data,
  output logic              tx_en,
  output logic              tx_empty
);

  logic              en_q;
  logic              empty_q;
  logic [DATA_W-1:0] hold_q;
  logic              hs;

  assign txs_valid = en_q & ~empty_q;
  assign txs_data  = hold_q;
  assign tx_en     = en_q;
  assign tx_empty  = empty_q;
  assign hs        = txs_valid & txs_ready;

  // misc reset acts before the enable field of the same byte
  always_ff @(posedge clk) begin
    if (rst)                 en_q <= 1'b0;
    else if (tx_on)          en_q <= 1'b1;
    else if (tx_off | tx_rst) en_q <= 1'b0;
  end

  // a buffer write outranks the handshake of the previous byte
  always_ff @(posedge clk) begin
    if (rst)               empty_q <= 1'b1;
    else if (buf_wr)       empty_q <= 1'b0;
    else if (tx_rst | hs)  empty_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)         hold_q <= '0;
    else if (buf_wr) hold_q <= buf_data;
  end

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (txs_valid && !txs_ready && !buf_wr && !tx_rst && !tx_off)
      |=> (txs_valid && $stable(txs_data)));

  assert_drain_after_hs_R6: assert property (@(posedge clk) disable iff (rst)
    (hs && !buf_wr) |=> !txs_valid);

  assert_write_pends_R7: assert property (@(posedge clk) disable iff (rst)
    buf_wr |=> (!tx_empty && txs_data == $past(buf_data)));

  assert_reset_discards_R13: assert property (@(posedge clk) disable iff (rst)
    (tx_rst && !buf_wr && !tx_on) |=> (!txs_valid && tx_empty));

endmodule

// File: rtl/uart_rb_irq.sv
module uart_rb_irq
  import uart_rb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr,
  input  logic [DATA_W-1:0] mask_in,
  input  logic              brk_evt,
  input  logic              brk_clr,
  input  logic              tx_rdy,
  input  logic              rx_avail,
  input  logic              rx_full,
  input  logic              rx_sel,
  output logic [DATA_W-1:0] isr,
  output logic              irq
);

  logic [DATA_W-1:0] mask_q;
  logic              brk_q;

  always_ff @(posedge clk) begin
    if (rst)          mask_q <= '0;
    else if (mask_wr) mask_q <= mask_in;
  end

  // an event in the clear cycle keeps the latch set
  always_ff @(posedge clk) begin
    if (rst)          brk_q <= 1'b0;
    else if (brk_evt) brk_q <= 1'b1;
    else if (brk_clr) brk_q <= 1'b0;
  end

  always_comb begin
    isr         = '0;
    isr[IS_TX]  = tx_rdy;
    isr[IS_RX]  = rx_sel ? rx_full : rx_avail;
    isr[IS_BRK] = brk_q;
  end

  assign irq = |(isr & mask_q);

  assert_brk_set_R11: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> isr[IS_BRK]);

  assert_brk_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (brk_clr && !brk_evt) |=> !isr[IS_BRK]);

  assert_mask_zero_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && mask_in == '0) |=> !irq);

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import uart_rb_pkg::*;
#(
  parameter int              ADDR_W    = 6,
  parameter int              DATA_W    = 8,
  parameter int              MODE_REGS = 2,
  parameter logic [DATA_W-1:0] DIV_A_VAL = 8'h00,
  parameter logic [DATA_W-1:0] DIV_B_VAL = 8'h1B
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              txs_valid,
  input  logic              txs_ready,
  output logic [DATA_W-1:0] txs_data,
  input  logic              rxq_avail,
  input  logic              rxq_full,
  input  logic [DATA_W-1:0] rxq_data,
  output logic              rxq_pop,
  output logic              rxq_flush,
  input  logic              rx_break,
  output logic              rx_enable
);

  localparam int PTR_W = (MODE_REGS > 1) ? $clog2(MODE_REGS) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(MODE_REGS - 1);

  // offset decode
  logic hit_mode, hit_stat, hit_cmd, hit_data, hit_int, hit_diva, hit_divb;
  assign hit_mode = (bus_addr == ADDR_W'(OFS_MODE));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_cmd  = (bus_addr == ADDR_W'(OFS_CMD));
  assign hit_data = (bus_addr == ADDR_W'(OFS_DATA));
  assign hit_int  = (bus_addr == ADDR_W'(OFS_INT));
  assign hit_diva = (bus_addr == ADDR_W'(OFS_DIVA));
  assign hit_divb = (bus_addr == ADDR_W'(OFS_DIVB));

  // command decode
  cmd_act_t act;
  uart_rb_cmd_dec u_cmd (
    .cmd_wr (bus_wr & hit_cmd),
    .cmd    (bus_wdata[6:0]),
    .act    (act)
  );

  // mode registers and pointer
  logic [DATA_W-1:0] mode_q [MODE_REGS];
  logic [PTR_W-1:0]  ptr_q;
  logic              mode_wr;
  assign mode_wr = bus_wr & hit_mode;

  generate
    for (genvar g = 0; g < MODE_REGS; g++) begin : g_mode
      always_ff @(posedge clk) begin
        if (rst)                                  mode_q[g] <= '0;
        else if (mode_wr && ptr_q == PTR_W'(g))   mode_q[g] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)               ptr_q <= '0;
    else if (mode_wr)      ptr_q <= (ptr_q == PTR_LAST) ? PTR_LAST : ptr_q + 1'b1;
    else if (act.ptr_rst)  ptr_q <= '0;
  end

  // receiver enable: reset field first, enable field last
  logic rx_en_q;
  always_ff @(posedge clk) begin
    if (rst)                         rx_en_q <= 1'b0;
    else if (act.rx_on)              rx_en_q <= 1'b1;
    else if (act.rx_off | act.rx_rst) rx_en_q <= 1'b0;
  end
  assign rx_enable = rx_en_q;
  assign rxq_flush = act.rx_rst;
  assign rxq_pop   = bus_rd & hit_data & rxq_avail;

  // transmit holding
  logic tx_en, tx_empty;
  uart_rb_tx_hold #(.DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .buf_wr    (bus_wr & hit_data),
    .buf_data  (bus_wdata),
    .tx_rst    (act.tx_rst),
    .tx_on     (act.tx_on),
    .tx_off    (act.tx_off),
    .txs_ready (txs_ready),
    .txs_valid (txs_valid),
    .txs_data  (txs_data),
    .tx_en     (tx_en),
    .tx_empty  (tx_empty)
  );

  // interrupt status and request
  logic [DATA_W-1:0] isr;
  uart_rb_irq #(.DATA_W(DATA_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .mask_wr  (bus_wr & hit_int),
    .mask_in  (bus_wdata),
    .brk_evt  (rx_break),
    .brk_clr  (act.brk_clr),
    .tx_rdy   (tx_en),
    .rx_avail (rxq_avail),
    .rx_full  (rxq_full),
    .rx_sel   (mode_q[0][MODE_RXSEL]),
    .isr      (isr),
    .irq      (irq)
  );

  // status byte
  logic [DATA_W-1:0] status;
  always_comb begin
    status           = '0;
    status[ST_RXAV]  = rxq_avail;
    status[ST_RXFL]  = rxq_full;
    status[ST_TXEN]  = tx_en;
    status[ST_TXEMP] = tx_empty;
  end

  // read mux, registered
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_mode)      rd_mux = mode_q[ptr_q];
    else if (hit_stat) rd_mux = status;
    else if (hit_data) rd_mux = rxq_avail ? rxq_data : '0;
    else if (hit_int)  rd_mux = isr;
    else if (hit_diva) rd_mux = DIV_A_VAL;
    else if (hit_divb) rd_mux = DIV_B_VAL;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (ptr_q != '0));

  assert_pop_needs_data_R8: assert property (@(posedge clk) disable iff (rst)
    rxq_pop |-> rxq_avail);

  assert_rx_on_R4: assert property (@(posedge clk) disable iff (rst)
    act.rx_on |=> rx_enable);

  assert_rx_reset_R5: assert property (@(posedge clk) disable iff (rst)
    (rxq_flush && !act.rx_on) |=> !rx_enable);

  assert_tx_on_R4: assert property (@(posedge clk) disable iff (rst)
    act.tx_on |=> isr[IS_TX]);

  assert_rdata_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] DIVA = 8'h05;
  localparam logic [7:0] DIVB = 8'hC3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, txs_valid;
  logic       txs_ready = 1'b0;
  logic [7:0] txs_data;
  logic       rxq_avail = 1'b0, rxq_full = 1'b0;
  logic [7:0] rxq_data = '0;
  logic       rxq_pop, rxq_flush;
  logic       rx_break = 1'b0;
  logic       rx_enable;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_regbank #(.DIV_A_VAL(DIVA), .DIV_B_VAL(DIVB)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .txs_valid(txs_valid),
    .txs_ready(txs_ready), .txs_data(txs_data), .rxq_avail(rxq_avail),
    .rxq_full(rxq_full), .rxq_data(rxq_data), .rxq_pop(rxq_pop),
    .rxq_flush(rxq_flush), .rx_break(rx_break), .rx_enable(rx_enable)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model and receive queue stand-in ----------
  logic [7:0] m_mr [2];
  int         m_ptr;
  bit         m_txen, m_rxen, m_empty, m_db;
  logic [7:0] m_tb, m_imr, m_rdata;
  logic [7:0] q[$];
  logic [7:0] sent[$];
  bit         push_req = 0;
  logic [7:0] push_byte = '0;

  function automatic logic [7:0] m_isr();
    logic rxbit;
    rxbit = m_mr[0][6] ? (q.size() == 4) : (q.size() > 0);
    return {5'b0, m_db, rxbit, m_txen};
  endfunction

  function automatic logic [7:0] m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_mr[m_ptr];
      6'h04: return {4'b0, m_empty, m_txen, q.size() == 4, q.size() > 0};
      6'h0C: return (q.size() > 0) ? q[0] : 8'h00;
      6'h14: return m_isr();
      6'h18: return DIVA;
      6'h1C: return DIVB;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    bit hs, pop, flush;
    if (rst) begin
      m_mr[0] = 0; m_mr[1] = 0; m_ptr = 0;
      m_txen = 0; m_rxen = 0; m_empty = 1; m_db = 0;
      m_tb = 0; m_imr = 0; m_rdata = 0;
      q.delete();
    end else begin
      hs    = !m_empty && m_txen && txs_ready;
      pop   = bus_rd && bus_addr == 6'h0C && q.size() > 0;
      flush = 0;
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (hs) m_empty = 1;
      if (bus_wr) begin
        case (bus_addr)
          6'h00: begin m_mr[m_ptr] = bus_wdata; m_ptr = 1; end
          6'h08: begin
            case (bus_wdata[6:4])
              3'd1: m_ptr = 0;
              3'd2: begin m_rxen = 0; flush = 1; end
              3'd3: begin m_txen = 0; m_empty = 1; end
              3'd5: m_db = 0;
              default: ;
            endcase
            if (bus_wdata[3:2] == 2'd1) m_txen = 1;
            if (bus_wdata[3:2] == 2'd2) m_txen = 0;
            if (bus_wdata[1:0] == 2'd1) m_rxen = 1;
            if (bus_wdata[1:0] == 2'd2) m_rxen = 0;
          end
          6'h0C: begin m_tb = bus_wdata; m_empty = 0; end
          6'h14: m_imr = bus_wdata;
          default: ;
        endcase
      end
      if (rx_break) m_db = 1;
      if (pop) void'(q.pop_front());
      if (flush) q.delete();
      if (push_req && q.size() < 4) q.push_back(push_byte);
    end
    rxq_avail <= (q.size() > 0);
    rxq_full  <= (q.size() == 4);
    rxq_data  <= (q.size() > 0) ? q[0] : 8'h00;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 txs_valid", 32'(txs_valid), 32'(!m_empty && m_txen));
      if (txs_valid) chk("R6 txs_data", 32'(txs_data), 32'(m_tb));
      chk("R10 irq", 32'(irq), 32'(|(m_isr() & m_imr)));
      chk("R4 rx_enable", 32'(rx_enable), 32'(m_rxen));
      chk("R8 rxq_pop", 32'(rxq_pop), 32'(bus_rd && bus_addr == 6'h0C && q.size() > 0));
      chk("R5 rxq_flush", 32'(rxq_flush), 32'(bus_wr && bus_addr == 6'h08 && bus_wdata[6:4] == 3'd2));
      chk("R3 bus_rdata", 32'(bus_rdata), 32'(m_rdata));
      if (txs_valid && txs_ready) sent.push_back(txs_data);
    end
  end

  // ---------------- drivers: entered and left at posedge + 1 ------------
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    bus_rd = 1; bus_addr = a;
    step();
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    push_req = 1; push_byte = b;
    step();
    push_req = 0;
  endtask

  task automatic brk_pulse();
    rx_break = 1;
    step();
    rx_break = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    step();

    // reset state
    rd(6'h04, v); chk("R1 status after reset", 32'(v), 32'h08);
    rd(6'h00, v); chk("R1 mode0 after reset", 32'(v), 32'h00);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 txs_valid after reset", 32'(txs_valid), 32'h0);
    chk("R1 rx_enable after reset", 32'(rx_enable), 32'h0);

    // mode pointer
    wr(6'h00, 8'h11);
    wr(6'h00, 8'h22);
    rd(6'h00, v); chk("R2 pointer stays on mode1", 32'(v), 32'h22);
    wr(6'h08, 8'h10);
    rd(6'h00, v); chk("R2 pointer reset to mode0", 32'(v), 32'h11);
    rd(6'h00, v); chk("R2 read does not advance", 32'(v), 32'h11);

    // enable fields
    wr(6'h08, 8'h05);
    rd(6'h04, v); chk("R4 both enabled status", 32'(v), 32'h0C);
    chk("R4 rx_enable on", 32'(rx_enable), 32'h1);
    wr(6'h08, 8'h0F);
    rd(6'h04, v); chk("R4 reserved codes ignored", 32'(v), 32'h0C);
    chk("R4 reserved keeps rx", 32'(rx_enable), 32'h1);
    wr(6'h08, 8'h0A);
    rd(6'h04, v); chk("R4 both disabled status", 32'(v), 32'h08);
    chk("R4 rx_enable off", 32'(rx_enable), 32'h0);

    // transmit holding
    wr(6'h0C, 8'hA5);
    chk("R6 disabled holds byte", 32'(txs_valid), 32'h0);
    rd(6'h04, v); chk("R6 empty cleared", 32'(v), 32'h00);
    wr(6'h08, 8'h04);
    chk("R6 enable presents byte", 32'(txs_valid), 32'h1);
    chk("R6 presented data", 32'(txs_data), 32'hA5);
    wr(6'h0C, 8'h3C);
    chk("R7 overwrite while stalled", 32'(txs_data), 32'h3C);
    txs_ready = 1;
    step();
    chk("R6 drained after handshake", 32'(txs_valid), 32'h0);
    rd(6'h04, v); chk("R6 empty set again", 32'(v), 32'h0C);
    wr(6'h0C, 8'h11);
    wr(6'h0C, 8'h22);
    chk("R7 write in handshake cycle pends", 32'(txs_valid), 32'h1);
    chk("R7 pending byte", 32'(txs_data), 32'h22);
    step(); step();
    txs_ready = 0;
    chk("R7 sent count", 32'(sent.size()), 32'd3);
    if (sent.size() == 3) begin
      chk("R7 first sent", 32'(sent[0]), 32'h3C);
      chk("R7 second sent", 32'(sent[1]), 32'h11);
      chk("R7 third sent", 32'(sent[2]), 32'h22);
    end

    // transmitter reset discards
    wr(6'h0C, 8'h77);
    chk("R13 byte pending", 32'(txs_valid), 32'h1);
    wr(6'h08, 8'h30);
    chk("R13 reset drops byte", 32'(txs_valid), 32'h0);
    rd(6'h04, v); chk("R13 status after tx reset", 32'(v), 32'h08);
    wr(6'h08, 8'h34);
    rd(6'h04, v); chk("R5 reset then enable", 32'(v), 32'h0C);
    chk("R13 byte not revived", 32'(txs_valid), 32'h0);

    // receive path
    push(8'h10); push(8'h20);
    rd(6'h04, v); chk("R3 rx ready bit", 32'(v), 32'h0D);
    rd(6'h0C, v); chk("R8 first byte", 32'(v), 32'h10);
    rd(6'h0C, v); chk("R8 second byte", 32'(v), 32'h20);
    rd(6'h0C, v); chk("R8 empty read zero", 32'(v), 32'h00);
    push(8'h01); push(8'h02); push(8'h03); push(8'h04);
    rd(6'h04, v); chk("R3 full bit", 32'(v), 32'h0F);
    wr(6'h08, 8'h21);
    chk("R5 rx reset then enable", 32'(rx_enable), 32'h1);
    rd(6'h04, v); chk("R5 queue flushed", 32'(v), 32'h0C);

    // interrupt status and request
    wr(6'h14, 8'h01);
    chk("R10 tx interrupt", 32'(irq), 32'h1);
    rd(6'h14, v); chk("R9 isr tx only", 32'(v), 32'h01);
    wr(6'h14, 8'h02);
    chk("R10 masked off", 32'(irq), 32'h0);
    push(8'h55);
    chk("R9 rx ready source", 32'(irq), 32'h1);
    wr(6'h08, 8'h10);
    wr(6'h00, 8'h40);
    chk("R9 full source not yet", 32'(irq), 32'h0);
    push(8'h56); push(8'h57); push(8'h58);
    chk("R9 full source", 32'(irq), 32'h1);
    rd(6'h14, v); chk("R9 isr tx and rx", 32'(v), 32'h03);
    wr(6'h08, 8'h20);

    // delta break
    wr(6'h14, 8'h04);
    brk_pulse();
    chk("R11 break sets", 32'(irq), 32'h1);
    rd(6'h14, v); chk("R11 isr break bit", 32'(v), 32'h05);
    wr(6'h08, 8'h50);
    chk("R11 clear command", 32'(irq), 32'h0);
    rx_break = 1;
    wr(6'h08, 8'h50);
    rx_break = 0;
    chk("R11 set wins over clear", 32'(irq), 32'h1);
    rd(6'h14, v); chk("R11 isr after collision", 32'(v), 32'h05);

    // ignored and constant offsets
    wr(6'h04, 8'hFF);
    rd(6'h04, v); chk("R12 status write ignored", 32'(v), 32'h0C);
    wr(6'h10, 8'hFF);
    rd(6'h10, v); chk("R12 aux reads zero", 32'(v), 32'h00);
    wr(6'h18, 8'h99);
    rd(6'h18, v); chk("R12 divider A", 32'(v), 32'(DIVA));
    rd(6'h1C, v); chk("R12 divider B", 32'(v), 32'(DIVB));
    rd(6'h3C, v); chk("R12 unmapped zero", 32'(v), 32'h00);

    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule